// File: doc/BRIEF.md
# Brownout Detector Control Logic

This block is the digital wrapper around an analog supply-brownout comparator and a low-voltage-reset detector. It synchronises the comparator output into the clock domain and reports the synchronised level as a status bit. It also latches a sticky event flag whenever the supply crosses the selected threshold, in either direction. Depending on a mode bit, a brownout either raises an interrupt request or asks the reset sequencer for a chip reset. The threshold select and low-power selection are driven straight out to the analog macro.

Software reaches the block through one 8-bit control/status word. The enable, threshold, mode, low-power and low-voltage-reset-enable fields are guarded. A write changes them only when an external unlock qualifier is high in the same cycle. The event flag is cleared by writing 1 to it, and the status bit is read-only. After the low-voltage-reset function is switched on, its request stays masked until a parameterised settling counter has run out.

Top module: `bod_ctrl`

## Requirements
- R1: After reset `rd_data` reads 0x80. The word layout is: bit0 enable, bits2:1 threshold select, bit3 mode (1 reset, 0 interrupt), bit4 event flag, bit5 low-power, bit6 status, bit7 low-voltage-reset enable. After reset all requests are low.
- R2: Bits 0,1,2,3,5,7 change on a write only while `unlocked` is high. Bit6 is never writable.
- R3: The comparator passes through a two-stage synchroniser. Bit6 reads 1 two clock edges after `cmp_below` rises, provided the block is enabled. While the block is disabled, bit6 reads 0.
- R4: While enabled, a change of the synchronised comparator in either direction sets the flag on the following edge, three edges after the input change. No flag is set while disabled.
- R5: Writing 1 to bit4 clears the flag. Writing 0 to bit4 leaves it unchanged. The clear needs no unlock.
- R6: When a flag set event and a write-1 clear fall in the same cycle, the flag stays set.
- R7: In interrupt mode with the block enabled, `irq` rises once the synchronised comparator is high. It stays high after the comparator falls, and drops one edge after enable is cleared.
- R8: In reset mode, `bod_rst_req` equals enable AND the synchronised comparator, and `irq` stays low.
- R9: `thr_sel` and `low_pwr` drive the stored threshold and low-power fields.
- R10: `lvr_rst_req` stays masked for SETTLE_CYC edges after low-voltage-reset enable is written to 1. After that it follows the synchronised `lvr_below`. Clearing the enable drops the request at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_below | input | 1 | Asynchronous brownout comparator output, 1 = supply below threshold |
| lvr_below | input | 1 | Asynchronous low-voltage detector output |
| unlocked | input | 1 | Write-protection released qualifier |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control/status word readback |
| thr_sel | output | 2 | Threshold select to the analog comparator |
| low_pwr | output | 1 | Low-power mode to the analog comparator |
| irq | output | 1 | Brownout interrupt request |
| bod_rst_req | output | 1 | Brownout chip-reset request |
| lvr_rst_req | output | 1 | Low-voltage reset request |

## Verification
A wrong synchroniser depth shows up as status and flag timing that is off by whole cycles. The bench checks the exact edge, before and after it. A flag register that misses one crossing direction stays low three edges after a falling input. A broken clear priority loses a flag that should persist. A stuck interrupt hold or a mis-gated enable appears at `irq` within one edge of the enable write. A settling counter off by one moves `lvr_rst_req` by one cycle at the boundary, and the bench samples on both sides of it.

// File: rtl/bod_pkg.sv
package bod_pkg;
  localparam int B_EN    = 0;
  localparam int B_THR_L = 1;
  localparam int B_THR_H = 2;
  localparam int B_MODE  = 3;
  localparam int B_FLAG  = 4;
  localparam int B_LP    = 5;
  localparam int B_STAT  = 6;
  localparam int B_LVR   = 7;
  localparam logic [7:0] GUARD_MASK = 8'b1010_1111;

  // new guarded fields: replace masked bits only when the write is allowed
  function automatic logic [7:0] guard_merge(input logic [7:0] old_v,
                                             input logic [7:0] wdata,
                                             input logic       allow);
    guard_merge = allow ? ((old_v & ~GUARD_MASK) | (wdata & GUARD_MASK)) : old_v;
  endfunction

  // sticky flag: set dominates clear
  function automatic logic flag_next(input logic cur, input logic set_ev,
                                     input logic clr_ev);
    flag_next = set_ev | (cur & ~clr_ev);
  endfunction
endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= din;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= '0;
      else        stg[g] <= stg[g-1];
    end
  end

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/bod_regs.sv
module bod_regs
  import bod_pkg::*;
#(
  parameter logic [7:0] RST_VAL = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       unlocked,
  input  logic       set_ev,
  output logic [7:0] cfg,
  output logic       flag
);
  logic guarded_wr;
  logic clr_ev;

  assign guarded_wr = wr_en & unlocked;
  assign clr_ev     = wr_en & wr_data[B_FLAG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg  <= RST_VAL & GUARD_MASK;
      flag <= 1'b0;
    end else begin
      cfg  <= guard_merge(cfg, wr_data, guarded_wr);
      flag <= flag_next(flag, set_ev, clr_ev);
    end
  end

  a_r2_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && unlocked) |=> $stable(cfg));
  a_r4_set_flag: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag);
  a_r5_clear_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_ev && !set_ev) |=> !flag);
endmodule

// File: rtl/bod_lvr_settle.sv
module bod_lvr_settle #(
  parameter int SETTLE_CYC = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic ready
);
  localparam int CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (!enable)       cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
  end

  assign ready = (cnt == LIMIT);

  a_r10_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (cnt == '0));
  a_r10_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && cnt != LIMIT) |=> (cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/bod_ctrl.sv
module bod_ctrl
  import bod_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         SETTLE_CYC  = 5000,
  parameter logic [7:0] RST_VAL     = 8'h80
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmp_below,
  input  logic       lvr_below,
  input  logic       unlocked,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic [1:0] thr_sel,
  output logic       low_pwr,
  output logic       irq,
  output logic       bod_rst_req,
  output logic       lvr_rst_req
);
  logic [1:0] sync_out;
  logic       cmp_s, lvr_s, cmp_d;
  logic [7:0] cfg;
  logic       flag;
  logic       en, rst_mode, lvr_en, lvr_ready;
  logic       cross_ev;
  logic       irq_q;

  bod_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({lvr_below, cmp_below}), .dout(sync_out));
  assign cmp_s = sync_out[0];
  assign lvr_s = sync_out[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_d <= 1'b0;
    else        cmp_d <= cmp_s;
  end

  assign en       = cfg[B_EN];
  assign rst_mode = cfg[B_MODE];
  assign lvr_en   = cfg[B_LVR];
  assign cross_ev = en & (cmp_s ^ cmp_d);

  bod_regs #(.RST_VAL(RST_VAL)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .unlocked(unlocked), .set_ev(cross_ev), .cfg(cfg), .flag(flag));

  bod_lvr_settle #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk(clk), .rst_n(rst_n), .enable(lvr_en), .ready(lvr_ready));

  // interrupt hold: latched in interrupt mode, released only by disable
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    irq_q <= 1'b0;
    else if (!en)                  irq_q <= 1'b0;
    else if (!rst_mode && cmp_s)   irq_q <= 1'b1;
  end

  always_comb begin
    rd_data         = cfg;
    rd_data[B_FLAG] = flag;
    rd_data[B_STAT] = en & cmp_s;
  end

  assign thr_sel     = cfg[B_THR_H:B_THR_L];
  assign low_pwr     = cfg[B_LP];
  assign irq         = irq_q;
  assign bod_rst_req = en & rst_mode & cmp_s;
  assign lvr_rst_req = lvr_en & lvr_ready & lvr_s;

  a_r7_irq_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq);
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && en) |=> irq);
  a_r3_status_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rd_data[B_STAT]);
endmodule

// File: tb/bod_ctrl_bench.sv
module bod_ctrl_bench;
  localparam int SETTLE = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmp_below = 1'b0, lvr_below = 1'b0, unlocked = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [1:0] thr_sel;
  logic       low_pwr, irq, bod_rst_req, lvr_rst_req;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  bod_ctrl #(.SETTLE_CYC(SETTLE)) u_bod_ctrl (
    .clk(clk), .rst_n(rst_n), .cmp_below(cmp_below), .lvr_below(lvr_below),
    .unlocked(unlocked), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .thr_sel(thr_sel), .low_pwr(low_pwr), .irq(irq),
    .bod_rst_req(bod_rst_req), .lvr_rst_req(lvr_rst_req));

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d, input logic unl);
    wr_en = 1'b1; wr_data = d; unlocked = unl;
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; unlocked = 1'b0;
  endtask

  initial begin
    #(64'd200000 * 20);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step(3); rst_n = 1'b1; step(1);
    chk("R1 word", rd_data, 8'h80);
    chk("R1 reqs", {5'b0, irq, bod_rst_req, lvr_rst_req}, 8'h00);

    wr(8'h2F, 1'b0);
    chk("R2 locked write", rd_data, 8'h80);
    wr(8'h2B, 1'b1);
    chk("R2 unlocked write", rd_data, 8'h2B);
    chk("R9 thr/lp", {5'b0, thr_sel, low_pwr}, 8'h03);
    wr(8'h41, 1'b1);
    chk("R2 status read-only", rd_data, 8'h01);

    cmp_below = 1'b1; step(1);
    chk("R3 one edge", {7'b0, rd_data[6]}, 8'h00);
    step(1);
    chk("R3 two edges", rd_data, 8'h41);
    step(1);
    chk("R4 rising sets flag", rd_data, 8'h51);
    chk("R7 irq raised", {7'b0, irq}, 8'h01);

    wr(8'h00, 1'b0);
    chk("R5 write zero keeps", {7'b0, rd_data[4]}, 8'h01);
    wr(8'h10, 1'b0);
    chk("R5 w1c", rd_data, 8'h41);

    cmp_below = 1'b0; step(4);
    chk("R4 falling sets flag", rd_data, 8'h11);
    chk("R7 irq held", {7'b0, irq}, 8'h01);
    wr(8'h10, 1'b0);

    cmp_below = 1'b1; step(2);
    wr(8'h10, 1'b0);
    chk("R6 set beats clear", {7'b0, rd_data[4]}, 8'h01);
    cmp_below = 1'b0; step(4);
    wr(8'h10, 1'b0);

    wr(8'h00, 1'b1);
    step(1);
    chk("R7 irq dropped", {7'b0, irq}, 8'h00);
    cmp_below = 1'b1; step(4);
    chk("R3 R4 disabled", rd_data, 8'h00);

    wr(8'h09, 1'b1);
    chk("R8 reset req", {6'b0, irq, bod_rst_req}, 8'h01);
    step(3);
    chk("R8 no irq", {7'b0, irq}, 8'h00);
    cmp_below = 1'b0; step(2);
    chk("R8 req follows", {7'b0, bod_rst_req}, 8'h00);

    lvr_below = 1'b1; step(3);
    chk("R10 off", {7'b0, lvr_rst_req}, 8'h00);
    wr(8'h89, 1'b1);
    step(SETTLE - 1);
    chk("R10 masked", {7'b0, lvr_rst_req}, 8'h00);
    step(1);
    chk("R10 settled", {7'b0, lvr_rst_req}, 8'h01);
    lvr_below = 1'b0; step(2);
    chk("R10 follows low", {7'b0, lvr_rst_req}, 8'h00);
    lvr_below = 1'b1; step(2);
    chk("R10 follows high", {7'b0, lvr_rst_req}, 8'h01);
    wr(8'h09, 1'b1);
    chk("R10 disable drops", {7'b0, lvr_rst_req}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule